// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Buffered Status

This block receives characters from an asynchronous serial line and buffers them for a consumer. An external baud generator supplies a one-cycle `baud_tick` enable at the oversampling rate. The block finds each start bit, confirms it with a majority vote, and samples every later bit by the same three-sample majority. It then stores the finished character, together with its own frame-error, parity-error and overrun flags, in a two-entry buffer. One more character can wait in a holding register behind the buffer.

The consumer reads the character at the head of the buffer from `rd_*` and removes it with a one-cycle `rd_pop` strobe. `rx_ready` shows that a character is available. `irq` is a registered request, gated by a local enable and a global enable. An address-filter mode lets a node on a shared line ignore every frame whose address bit is clear. A double-speed option shortens each bit from 16 ticks to 8.

Top module: `serial_rx_core`

## Requirements
- R1: A start is seen on a high-to-low transition of the line at a tick. It is confirmed when the majority of samples 7, 8 and 9 (16x) is low. Eight data bits follow, least significant first, and then one stop bit, each bit taken as the majority of its three middle samples. The character is presented on `rd_data`.
- R2: Up to three unread characters are kept without loss: two in the buffer and one in the holding register. They are delivered in arrival order.
- R3: Overrun occurs when the buffer is full, a character is waiting in the holding register, and a new start is detected. The waiting character is then discarded, and the next character that is stored carries `rd_overrun`=1.
- R4: `rd_frame_err` is 1 for a character whose stop bit sampled low, and 0 when it sampled high.
- R5: When parity is enabled at the start of a frame, one parity bit follows the data bits (and the ninth bit, if present). The parity covers those bits and is even when `cfg_par_odd`=0 and odd when it is 1. A mismatch sets `rd_par_err` for that character. With parity disabled there is no parity bit and `rd_par_err` is 0.
- R6: The error flags belong to each stored character. The `rd_*` outputs always describe the head entry, and after a pop they describe the next entry.
- R7: With `cfg_fast`=1 a bit lasts 8 ticks and the vote uses samples 3, 4 and 5. With `cfg_fast`=0 a bit lasts 16 ticks.
- R8: With `cfg_nine_bit`=1 a ninth bit follows the eight data bits and is stored and shown on `rd_bit8`. When no ninth bit position is in the frame, `rd_bit8` is 0.
- R9: With `cfg_addr_filter`=1 the frame always carries the ninth (address) bit position, even when `cfg_nine_bit`=0. Frames whose address bit is 0 are discarded and never stored. Frames whose address bit is 1 are stored with `rd_bit8`=1.
- R10: `rx_ready` is 1 exactly when the buffer holds a character. A pop while the buffer is empty has no effect.
- R11: `irq` is 1 one cycle after `cfg_irq_en`, `glb_irq_en` and `rx_ready` are all 1, and 0 otherwise.
- R12: A synchronous active-high `rst` empties the buffer and the holding register, clears all flags and `irq`, and returns the receiver to waiting for a start.
- R13: A low pulse whose middle majority samples high is rejected as a false start, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | Oversampling enable, one cycle wide |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_nine_bit | input | 1 | Ninth data bit present |
| cfg_fast | input | 1 | 8 ticks per bit instead of 16 |
| cfg_addr_filter | input | 1 | Discard frames whose address bit is clear |
| cfg_irq_en | input | 1 | Local receive interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Head character, low eight bits |
| rd_bit8 | output | 1 | Head character, ninth or address bit |
| rd_frame_err | output | 1 | Head character had a low stop bit |
| rd_par_err | output | 1 | Head character failed parity |
| rd_overrun | output | 1 | A character was lost before the head character |
| rx_ready | output | 1 | Buffer not empty |
| irq | output | 1 | Gated receive interrupt request |

## Verification
The hardest state to reach is overrun. It needs both buffer slots full, a third character parked in the holding register, and then another start edge, all while the consumer stays idle. The bench turns off its reading monitor, sends three characters and then a fourth. It then turns the monitor back on and expects the first two characters clean, the third missing, and the fourth tagged with overrun. Per-entry flags are reached the same way: an erroneous character and a clean one are buffered together before either is read.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W = 8;
  localparam int CHAR_W = DATA_W + 1;

  typedef enum logic {S_IDLE, S_BITS} rx_state_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              frame_err;
    logic              par_err;
    logic              overrun;
  } rx_entry_t;
endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import serial_rx_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              tick,
  input  logic              cfg_fast,
  input  logic              cfg_extra,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_addr_flt,
  output logic              start_seen,
  output logic              frm_valid,
  output logic [CHAR_W-1:0] frm_data,
  output logic              frm_fe,
  output logic              frm_pe,
  output logic              frm_drop
);
  localparam int CW = $clog2(OSR_NORM);
  localparam int IW = $clog2(CHAR_W + 4);
  localparam logic [CW-1:0] LAST_N = CW'(OSR_NORM - 1);
  localparam logic [CW-1:0] LAST_F = CW'(OSR_FAST - 1);
  localparam logic [CW-1:0] MID_N  = CW'(OSR_NORM / 2);
  localparam logic [CW-1:0] MID_F  = CW'(OSR_FAST / 2);

  logic              sync1, rx_s, prev;
  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [2:0]        votes;
  logic [CHAR_W-1:0] shreg;
  logic              acc;
  logic              fast_q, ext_q, par_q, odd_q, addr_q;

  logic [CW-1:0] last_c, mid_c;
  logic          in_win, bit_v, store_bit;
  logic [IW-1:0] stop_idx, wr_pos;

  always_comb begin
    last_c    = fast_q ? LAST_F : LAST_N;
    mid_c     = fast_q ? MID_F : MID_N;
    in_win    = (cnt == mid_c - CW'(1)) || (cnt == mid_c) || (cnt == mid_c + CW'(1));
    bit_v     = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
    stop_idx  = IW'(CHAR_W) + IW'(ext_q) + IW'(par_q);
    wr_pos    = idx - IW'(1);
    store_bit = (idx <= IW'(CHAR_W - 1)) || (ext_q && idx == IW'(CHAR_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      sync1 <= rx_in;
      rx_s  <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; prev <= 1'b1; cnt <= '0; idx <= '0; votes <= '0;
      shreg <= '0; acc <= 1'b0;
      fast_q <= 1'b0; ext_q <= 1'b0; par_q <= 1'b0; odd_q <= 1'b0; addr_q <= 1'b0;
      start_seen <= 1'b0; frm_valid <= 1'b0; frm_data <= '0;
      frm_fe <= 1'b0; frm_pe <= 1'b0; frm_drop <= 1'b0;
    end else begin
      start_seen <= 1'b0;
      frm_valid  <= 1'b0;
      if (tick) begin
        prev <= rx_s;
        case (st)
          S_IDLE: begin
            if (prev && !rx_s) begin
              st <= S_BITS; cnt <= CW'(1); idx <= '0; votes <= '0;
              shreg <= '0; acc <= 1'b0; start_seen <= 1'b1;
              fast_q <= cfg_fast; ext_q <= cfg_extra; par_q <= cfg_par_en;
              odd_q <= cfg_par_odd; addr_q <= cfg_addr_flt;
            end
          end
          default: begin
            if (in_win) votes <= {votes[1:0], rx_s};
            if (cnt == last_c) begin
              cnt <= '0;
              if (idx == '0) begin
                if (bit_v) st <= S_IDLE;
                else idx <= IW'(1);
              end else if (idx == stop_idx) begin
                frm_valid <= 1'b1;
                frm_data  <= shreg;
                frm_fe    <= ~bit_v;
                frm_pe    <= par_q & (acc ^ odd_q);
                frm_drop  <= addr_q & ~shreg[CHAR_W-1];
                st        <= S_IDLE;
              end else begin
                if (store_bit) shreg[wr_pos] <= bit_v;
                acc <= acc ^ bit_v;
                idx <= idx + IW'(1);
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        endcase
      end
    end
  end

  assert_fast_window_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_BITS && fast_q) |-> (cnt <= LAST_F));
  assert_frame_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> !frm_valid);
  assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (rst)
    start_seen |-> (st == S_BITS && idx == '0));
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  output rx_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]   PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_push, do_pop;

  assign full    = (count == CNT_FULL);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  parameter int DEPTH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              baud_tick,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_nine_bit,
  input  logic              cfg_fast,
  input  logic              cfg_addr_filter,
  input  logic              cfg_irq_en,
  input  logic              glb_irq_en,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit8,
  output logic              rd_frame_err,
  output logic              rd_par_err,
  output logic              rd_overrun,
  output logic              rx_ready,
  output logic              irq
);
  logic              start_seen, frm_valid, frm_fe, frm_pe, frm_drop;
  logic [CHAR_W-1:0] frm_data;
  rx_entry_t         hold_q, head;
  logic              hold_v, ovr_arm, fifo_full, fifo_empty, irq_q;

  rx_bit_sampler #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_sampler (
    .clk(clk), .rst(rst), .rx_in(rx_line), .tick(baud_tick),
    .cfg_fast(cfg_fast), .cfg_extra(cfg_nine_bit | cfg_addr_filter),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_addr_flt(cfg_addr_filter),
    .start_seen(start_seen), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_fe(frm_fe), .frm_pe(frm_pe), .frm_drop(frm_drop)
  );

  rx_frame_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(hold_v), .din(hold_q), .pop(rd_pop),
    .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0; hold_v <= 1'b0; ovr_arm <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= cfg_irq_en & glb_irq_en & ~fifo_empty;
      if (hold_v && !fifo_full) hold_v <= 1'b0;
      if (start_seen && fifo_full && hold_v) begin
        hold_v  <= 1'b0;
        ovr_arm <= 1'b1;
      end
      if (frm_valid && !frm_drop) begin
        hold_q  <= '{data: frm_data, frame_err: frm_fe, par_err: frm_pe, overrun: ovr_arm};
        hold_v  <= 1'b1;
        ovr_arm <= 1'b0;
      end
    end
  end

  assign rx_ready     = ~fifo_empty;
  assign rd_data      = fifo_empty ? '0 : head.data[DATA_W-1:0];
  assign rd_bit8      = fifo_empty ? 1'b0 : head.data[CHAR_W-1];
  assign rd_frame_err = fifo_empty ? 1'b0 : head.frame_err;
  assign rd_par_err   = fifo_empty ? 1'b0 : head.par_err;
  assign rd_overrun   = fifo_empty ? 1'b0 : head.overrun;
  assign irq          = irq_q;

  assert_filter_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_drop && !hold_v) |=> !hold_v);
  assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_arm) |-> $past(fifo_full && hold_v));
  assert_irq_needs_data_R11: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_empty) |-> !irq);
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;

  typedef struct {
    logic [8:0] d;
    logic       fe, pe, ov;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, rx_line = 1'b1, baud_tick = 1'b0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_nine_bit = 0, cfg_fast = 0;
  logic cfg_addr_filter = 0, cfg_irq_en = 0, glb_irq_en = 0;
  logic mon_pop = 0, empty_pop = 0, rd_pop;
  logic [7:0] rd_data;
  logic rd_bit8, rd_frame_err, rd_par_err, rd_overrun, rx_ready, irq;
  logic mon_en = 0;
  int checks = 0, errors = 0;
  exp_t exp_q[$];

  assign rd_pop = mon_pop | empty_pop;

  serial_rx_core u_dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .baud_tick(baud_tick),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_nine_bit(cfg_nine_bit),
    .cfg_fast(cfg_fast), .cfg_addr_filter(cfg_addr_filter), .cfg_irq_en(cfg_irq_en),
    .glb_irq_en(glb_irq_en), .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit8(rd_bit8),
    .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err), .rd_overrun(rd_overrun),
    .rx_ready(rx_ready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) baud_tick <= ~baud_tick;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    if (mon_en && rx_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected character", {23'd0, rd_bit8, rd_data}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({rd_bit8, rd_data} == e.d && rd_frame_err == e.fe && rd_par_err == e.pe
            && rd_overrun == e.ov, e.tag, "char/fe/pe/ov",
            {19'd0, rd_bit8, rd_data, rd_frame_err, rd_par_err, rd_overrun},
            {19'd0, e.d, e.fe, e.pe, e.ov});
      end
      mon_pop = 1'b1;
      @(negedge clk);
      mon_pop = 1'b0;
    end
  end

  task automatic hold_bit(input logic b);
    int n;
    n = (cfg_fast ? 8 : 16) * TICK_DIV;
    rx_line = b;
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame using the current configuration and records what should be stored.
  task automatic send_char(input logic [8:0] v, input logic bad_par, input logic stop_v,
                           input logic store, input logic ov, input string tag);
    logic extra;
    logic p;
    exp_t e;
    extra = cfg_nine_bit | cfg_addr_filter;
    p = (^v[7:0]) ^ (extra & v[8]) ^ cfg_par_odd ^ bad_par;
    if (store) begin
      e.d = extra ? v : {1'b0, v[7:0]};
      e.fe = ~stop_v; e.pe = cfg_par_en & bad_par; e.ov = ov; e.tag = tag;
      exp_q.push_back(e);
    end
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(v[i]);
    if (extra) hold_bit(v[8]);
    if (cfg_par_en) hold_bit(p);
    hold_bit(stop_v);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((exp_q.size() != 0 || rx_ready) && n < 4000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, tag, "expected items left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(rx_ready == 0 && irq == 0, "R12", "ready/irq after reset", {rx_ready, irq}, 0);
    chk(rd_frame_err == 0 && rd_par_err == 0 && rd_overrun == 0, "R12", "flags after reset",
        {rd_frame_err, rd_par_err, rd_overrun}, 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    mon_en = 1'b1;

    // R1 plain 8-bit frames
    send_char(9'h0A5, 0, 1, 1, 0, "R1");
    send_char(9'h03C, 0, 1, 1, 0, "R1");
    send_char(9'h000, 0, 1, 1, 0, "R1");
    send_char(9'h0FF, 0, 1, 1, 0, "R1");
    drain("R1");

    // R5 parity even and odd, good and bad
    cfg_par_en = 1;
    send_char(9'h05A, 0, 1, 1, 0, "R5");
    send_char(9'h05B, 1, 1, 1, 0, "R5");
    cfg_par_odd = 1;
    send_char(9'h0C3, 0, 1, 1, 0, "R5");
    send_char(9'h0C7, 1, 1, 1, 0, "R5");
    cfg_par_en = 0; cfg_par_odd = 0;
    drain("R5");

    // R4 frame error and R6 per-entry flags buffered together
    mon_en = 0;
    send_char(9'h081, 0, 0, 1, 0, "R4");
    send_char(9'h042, 0, 1, 1, 0, "R6");
    cfg_par_en = 1;
    send_char(9'h013, 1, 1, 1, 0, "R6");
    cfg_par_en = 0;
    mon_en = 1;
    drain("R6");

    // R8 nine-bit frames, with parity on one
    cfg_nine_bit = 1;
    send_char(9'h1AB, 0, 1, 1, 0, "R8");
    send_char(9'h0CD, 0, 1, 1, 0, "R8");
    cfg_par_en = 1;
    send_char(9'h155, 1, 1, 1, 0, "R8");
    cfg_par_en = 0;
    drain("R8");

    // R9 address filtering, nine-bit then eight-bit
    cfg_addr_filter = 1;
    send_char(9'h110, 0, 1, 1, 0, "R9");
    send_char(9'h020, 0, 1, 0, 0, "R9");
    send_char(9'h130, 0, 1, 1, 0, "R9");
    cfg_nine_bit = 0;
    send_char(9'h144, 0, 1, 1, 0, "R9");
    send_char(9'h055, 0, 1, 0, 0, "R9");
    drain("R9");
    cfg_addr_filter = 0;

    // R7 double speed
    cfg_fast = 1;
    send_char(9'h077, 0, 1, 1, 0, "R7");
    cfg_par_en = 1;
    send_char(9'h0E1, 1, 1, 1, 0, "R7");
    cfg_par_en = 0;
    drain("R7");
    cfg_fast = 0;

    // R13 false start
    rx_line = 0;
    repeat (2 * TICK_DIV) @(negedge clk);
    rx_line = 1;
    repeat (64 * TICK_DIV) @(negedge clk);
    chk(rx_ready == 0, "R13", "ready after glitch", rx_ready, 0);
    send_char(9'h09C, 0, 1, 1, 0, "R13");
    drain("R13");

    // R10 pop on empty
    mon_en = 0;
    chk(rx_ready == 0, "R10", "ready when empty", rx_ready, 0);
    empty_pop = 1; @(negedge clk); empty_pop = 0;
    repeat (3) @(negedge clk);
    chk(rx_ready == 0, "R10", "ready after empty pop", rx_ready, 0);
    send_char(9'h0D2, 0, 1, 1, 0, "R10");
    repeat (4) @(negedge clk);
    chk(rx_ready == 1, "R10", "ready with one char", rx_ready, 1);
    mon_en = 1;
    drain("R10");

    // R2 three characters held without reading
    mon_en = 0;
    send_char(9'h061, 0, 1, 1, 0, "R2");
    send_char(9'h062, 0, 1, 1, 0, "R2");
    send_char(9'h063, 0, 1, 1, 0, "R2");
    mon_en = 1;
    drain("R2");

    // R3 overrun and R11 interrupt gating
    mon_en = 0;
    send_char(9'h011, 0, 1, 1, 0, "R3");
    send_char(9'h022, 0, 1, 1, 0, "R3");
    send_char(9'h033, 0, 1, 0, 0, "R3");
    cfg_irq_en = 0; glb_irq_en = 1; repeat (3) @(negedge clk);
    chk(irq == 0, "R11", "irq local off", irq, 0);
    cfg_irq_en = 1; glb_irq_en = 0; repeat (3) @(negedge clk);
    chk(irq == 0, "R11", "irq global off", irq, 0);
    cfg_irq_en = 1; glb_irq_en = 1; repeat (3) @(negedge clk);
    chk(irq == 1, "R11", "irq all on", irq, 1);
    send_char(9'h044, 0, 1, 1, 1, "R3");
    mon_en = 1;
    drain("R3");
    chk(irq == 0, "R11", "irq when empty", irq, 0);
    cfg_irq_en = 0; glb_irq_en = 0;

    // R12 reset clears buffered data
    mon_en = 0;
    send_char(9'h0EE, 0, 0, 0, 0, "R12");
    cfg_irq_en = 1; glb_irq_en = 1;
    repeat (3) @(negedge clk);
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    chk(rx_ready == 0 && irq == 0, "R12", "ready/irq after mid reset", {rx_ready, irq}, 0);
    chk(rd_frame_err == 0, "R12", "frame flag after mid reset", rd_frame_err, 0);
    cfg_irq_en = 0; glb_irq_en = 0;
    mon_en = 1;
    send_char(9'h05E, 0, 1, 1, 0, "R12");
    drain("R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule